// File: doc/BRIEF.md
# Interrupt priority acceptance unit

This unit decides, once per handling sequence, whether a pending interrupt is taken. A maskable request carries a 4-bit priority level and a vector number. It is compared with the 4-bit mask value that the core currently holds in its status register. A separate non-maskable request bypasses that comparison. It ranks one step above the highest maskable level, so it acts as level 16.

Once a request is taken, the unit latches the winning vector and pulses an accept strobe. It then steps the core through the entry sequence with one handshake per stage:
- ask for the handler address lookup by vector, and wait for completion;
- ask for the status and program counter to be pushed, and wait for completion;
- write the new mask value for one cycle;
- issue a single-cycle jump request.

The jump request is not a delayed branch. No delay-slot stage exists between it and the return to idle. New requests are ignored until that return.

Top module: `irq_accept_unit`

## Requirements
- R1: When idle, a non-maskable request (`nmi_req`=1) is accepted whatever `mask_in` holds; `accept` goes high in the cycle after the request is sampled.
- R2: When idle, a maskable request (`irq_req`=1, no `nmi_req`) is accepted only if `irq_level` is strictly greater than `mask_in`; otherwise `accept` stays low and no sequence starts.
- R3: When both requests are present in the same idle cycle, the non-maskable one wins and `acc_vector` equals parameter `NMI_VECTOR` (default 8'h0B).
- R4: `accept` is high for exactly one clock; `acc_vector` is valid in that cycle and holds the taken vector until the jump cycle ends.
- R5: `vec_fetch_req` is high from the accept cycle until the cycle in which `vec_fetch_done` is sampled high; `save_req` is then high from the next cycle until `save_done` is sampled high; at most one of `vec_fetch_req`, `save_req`, `mask_wr`, `jump_req` is high in any cycle.
- R6: `mask_wr` is high for exactly one cycle, the cycle after `save_done` is sampled; for a maskable request `mask_new` then equals the accepted `irq_level`.
- R7: For a non-maskable request `mask_new` is 4'hF (all ones), although its effective level is 16.
- R8: `jump_req` is high for exactly one cycle, immediately after the `mask_wr` cycle, and the unit is idle in the next cycle, with no delay-slot stage.
- R9: Requests presented while a sequence is in progress are ignored: no second `accept` occurs, and `acc_vector` and `mask_new` do not change.
- R10: During and just after synchronous active-low reset, `accept`, `vec_fetch_req`, `save_req`, `mask_wr` and `jump_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Maskable interrupt request |
| irq_level | input | 4 | Priority level of the maskable request |
| irq_vector | input | 8 | Vector number of the maskable request |
| mask_in | input | 4 | Current mask value from the status register |
| vec_fetch_done | input | 1 | Handler address lookup completed |
| save_done | input | 1 | Status and program counter push completed |
| accept | output | 1 | One-cycle strobe: a request was taken |
| acc_vector | output | 8 | Vector number of the taken request |
| vec_fetch_req | output | 1 | Request handler address lookup by vector |
| save_req | output | 1 | Request push of status and program counter |
| mask_wr | output | 1 | Write strobe for the mask field |
| mask_new | output | 4 | New mask value to write |
| jump_req | output | 1 | One-cycle non-delayed jump to the handler |

## Verification
On every cycle the assertions check the following:
- the single-cycle width of `accept`, `mask_wr` and `jump_req`;
- that the handshake outputs are mutually exclusive;
- the fixed stage-to-stage spacing after each completion;
- that an idle non-maskable request is always taken and a maskable one at or below the mask is never taken;
- that acceptance only happens from idle.

Only the bench scenarios can show the actual values of the taken vector and the written mask. This covers the all-ones mask for the non-maskable case, the win of the non-maskable request in a tie, and the strict comparison at the equal-level boundary. The bench also shows that requests driven during a busy sequence leave the outputs unchanged.

// File: rtl/irq_accept_pkg.sv
// Package: shared state type and sizing for the interrupt acceptance unit.
// Assumes a single clock domain; no tool-specific content.
package irq_accept_pkg;

    // Sequencer stages, in the order the entry sequence runs them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_SAVE  = 3'd2,
        ST_MASK  = 3'd3,
        ST_JUMP  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/irq_pick.sv
// Module: irq_pick
// Purely combinational arbiter. It forms an effective level one bit wider
// than the mask, so the non-maskable request ranks above every maskable
// level. It decides whether a request is taken and which vector and mask
// value go with it.
// Assumes the caller only uses the result while the sequencer is idle.
module irq_pick #(
    parameter int          LVL_W      = 4,
    parameter int          VEC_W      = 8,
    parameter logic [7:0]  NMI_VECTOR = 8'h0B
) (
    input  logic             nmi_req,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [VEC_W-1:0] irq_vector,
    input  logic [LVL_W-1:0] mask_in,
    output logic             take,
    output logic [VEC_W-1:0] sel_vector,
    output logic [LVL_W-1:0] sel_mask
);
    localparam int          EFF_W    = LVL_W + 1;
    localparam logic [EFF_W-1:0] NMI_EFF  = EFF_W'(1) << LVL_W;
    localparam logic [LVL_W-1:0] MASK_TOP = '1;

    logic [EFF_W-1:0] eff_level;
    logic [EFF_W-1:0] eff_mask;

    // Effective level: non-maskable ranks at 2**LVL_W, above any mask.
    always_comb begin
        eff_mask  = {1'b0, mask_in};
        if (nmi_req) begin
            eff_level = NMI_EFF;
        end else if (irq_req) begin
            eff_level = {1'b0, irq_level};
        end else begin
            eff_level = '0;
        end
    end

    // Decision and selection: strict compare; saturate the level into the mask field.
    always_comb begin
        take       = (nmi_req || irq_req) && (eff_level > eff_mask);
        sel_vector = nmi_req ? VEC_W'(NMI_VECTOR) : irq_vector;
        sel_mask   = eff_level[LVL_W] ? MASK_TOP : eff_level[LVL_W-1:0];
    end

    // A non-maskable request is never refused by the compare.
    always_comb begin
        AST_NMI_NEVER_REFUSED: assert (!nmi_req || take); // R1
    end

endmodule

// File: rtl/irq_seq.sv
// Module: irq_seq
// Entry sequencer. It runs these stages in order: vector fetch, context
// save, mask write and jump. It latches the vector and mask chosen at
// acceptance and holds them until the jump cycle ends.
// Assumes the fetch and save done inputs are sampled only in their own
// stage.
module irq_seq
    import irq_accept_pkg::*;
#(
    parameter int LVL_W = 4,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [VEC_W-1:0] sel_vector,
    input  logic [LVL_W-1:0] sel_mask,
    input  logic             vec_fetch_done,
    input  logic             save_done,
    output logic             accept,
    output logic [VEC_W-1:0] acc_vector,
    output logic             vec_fetch_req,
    output logic             save_req,
    output logic             mask_wr,
    output logic [LVL_W-1:0] mask_new,
    output logic             jump_req,
    output logic             idle
);
    seq_state_t state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic [LVL_W-1:0] mask_q;
    logic             accept_q;

    // Next-stage logic: leave idle only on a take; advance on each completion.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take)           state_d = ST_FETCH;
            ST_FETCH: if (vec_fetch_done) state_d = ST_SAVE;
            ST_SAVE:  if (save_done)      state_d = ST_MASK;
            ST_MASK:                      state_d = ST_JUMP;
            ST_JUMP:                      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // State register and acceptance strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            accept_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            accept_q <= (state_q == ST_IDLE) && take;
        end
    end

    // Capture vector and mask value at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            mask_q <= '0;
        end else if ((state_q == ST_IDLE) && take) begin
            vec_q  <= sel_vector;
            mask_q <= sel_mask;
        end
    end

    // Output decode from the current stage.
    always_comb begin
        idle          = (state_q == ST_IDLE);
        accept        = accept_q;
        acc_vector    = vec_q;
        mask_new      = mask_q;
        vec_fetch_req = (state_q == ST_FETCH);
        save_req      = (state_q == ST_SAVE);
        mask_wr       = (state_q == ST_MASK);
        jump_req      = (state_q == ST_JUMP);
    end

    AST_ACCEPT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept); // R4
    AST_STAGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vec_fetch_req, save_req, mask_wr, jump_req})); // R5
    AST_FETCH_TO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch_req && vec_fetch_done) |=> save_req); // R5
    AST_MASK_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && save_done) |=> (mask_wr && !save_req)); // R6
    AST_MASK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (!mask_wr && jump_req)); // R8
    AST_JUMP_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |=> (!jump_req && !vec_fetch_req && !save_req)); // R8
    AST_VECTOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !accept) |-> $stable(acc_vector)); // R9

endmodule

// File: rtl/irq_accept_unit.sv
// Module: irq_accept_unit (top)
// Decides whether a pending interrupt is taken, and drives the entry
// handshake sequence with the chosen vector and mask value.
// Assumes mask_in reflects the status register mask field and that
// requests are level signals that the requester holds until acceptance.
module irq_accept_unit #(
    parameter int         LVL_W      = 4,
    parameter int         VEC_W      = 8,
    parameter logic [7:0] NMI_VECTOR = 8'h0B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_req,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [VEC_W-1:0] irq_vector,
    input  logic [LVL_W-1:0] mask_in,
    input  logic             vec_fetch_done,
    input  logic             save_done,
    output logic             accept,
    output logic [VEC_W-1:0] acc_vector,
    output logic             vec_fetch_req,
    output logic             save_req,
    output logic             mask_wr,
    output logic [LVL_W-1:0] mask_new,
    output logic             jump_req
);
    logic             take;
    logic [VEC_W-1:0] sel_vector;
    logic [LVL_W-1:0] sel_mask;
    logic             idle;

    irq_pick #(
        .LVL_W(LVL_W), .VEC_W(VEC_W), .NMI_VECTOR(NMI_VECTOR)
    ) u_pick (
        .nmi_req(nmi_req), .irq_req(irq_req), .irq_level(irq_level),
        .irq_vector(irq_vector), .mask_in(mask_in),
        .take(take), .sel_vector(sel_vector), .sel_mask(sel_mask)
    );

    irq_seq #(
        .LVL_W(LVL_W), .VEC_W(VEC_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .take(take),
        .sel_vector(sel_vector), .sel_mask(sel_mask),
        .vec_fetch_done(vec_fetch_done), .save_done(save_done),
        .accept(accept), .acc_vector(acc_vector),
        .vec_fetch_req(vec_fetch_req), .save_req(save_req),
        .mask_wr(mask_wr), .mask_new(mask_new), .jump_req(jump_req),
        .idle(idle)
    );

    AST_NMI_TAKEN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && nmi_req) |=> accept); // R1
    AST_MASKED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !nmi_req && irq_req && (irq_level <= mask_in)) |=> !accept); // R2
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle) |=> !accept); // R9

endmodule

// File: tb/irq_accept_unit_bench.sv
// Bench: directed corners plus seeded random requests; expected values
// come from bench functions built on the requirements.
module irq_accept_unit_bench;
    localparam logic [7:0] NMI_VEC = 8'h0B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_req = 1'b0, irq_req = 1'b0;
    logic [3:0] irq_level = '0, mask_in = '0;
    logic [7:0] irq_vector = '0;
    logic       vec_fetch_done = 1'b0, save_done = 1'b0;
    logic       accept, vec_fetch_req, save_req, mask_wr, jump_req;
    logic [7:0] acc_vector;
    logic [3:0] mask_new;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_accept_unit u_irq_accept_unit (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
        .irq_level(irq_level), .irq_vector(irq_vector), .mask_in(mask_in),
        .vec_fetch_done(vec_fetch_done), .save_done(save_done),
        .accept(accept), .acc_vector(acc_vector),
        .vec_fetch_req(vec_fetch_req), .save_req(save_req),
        .mask_wr(mask_wr), .mask_new(mask_new), .jump_req(jump_req)
    );

    function automatic bit exp_take(bit n, bit i, logic [3:0] lvl, logic [3:0] m);
        return n || (i && (lvl > m));
    endfunction
    function automatic logic [7:0] exp_vec(bit n, logic [7:0] v);
        return n ? NMI_VEC : v;
    endfunction
    function automatic logic [3:0] exp_mask(bit n, logic [3:0] lvl);
        return n ? 4'hF : lvl;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive busy-time noise requests (R9: must be ignored).
    task automatic noise(bit on);
        nmi_req    = on ? 1'($urandom) : 1'b0;
        irq_req    = on ? 1'($urandom) : 1'b0;
        irq_level  = on ? 4'($urandom) : 4'h0;
        irq_vector = on ? 8'($urandom) : 8'h0;
        mask_in    = on ? 4'($urandom) : 4'h0;
    endtask

    // One full scenario starting from idle, at a negedge.
    task automatic run(bit n, bit i, logic [3:0] lvl, logic [7:0] v,
                       logic [3:0] m, int fd, int sd, bit busy_noise);
        bit         t  = exp_take(n, i, lvl, m);
        logic [7:0] ev = exp_vec(n, v);
        logic [3:0] em = exp_mask(n, lvl);
        nmi_req = n; irq_req = i; irq_level = lvl; irq_vector = v; mask_in = m;
        step();
        if (!t) begin
            chk("R2 refused accept", accept, 0);
            chk("R2 refused no fetch", vec_fetch_req, 0);
            noise(0);
            step();
            chk("R2 still idle", vec_fetch_req, 0);
            return;
        end
        chk(n ? (i ? "R3 tie accept" : "R1 nmi accept") : "R2 accept", accept, 1);
        chk(n && i ? "R3 nmi vector wins" : "R4 vector", acc_vector, ev);
        chk("R5 fetch req", vec_fetch_req, 1);
        noise(busy_noise);
        for (int k = 0; k < fd; k++) begin
            step();
            chk("R4 accept one cycle", accept, 0);
            chk("R5 fetch held", vec_fetch_req, 1);
            noise(busy_noise);
        end
        vec_fetch_done = 1'b1;
        step();
        vec_fetch_done = 1'b0;
        chk("R5 save req", save_req, 1);
        chk("R5 fetch dropped", vec_fetch_req, 0);
        chk("R9 no accept when busy", accept, 0);
        for (int k = 0; k < sd; k++) begin
            noise(busy_noise);
            step();
            chk("R5 save held", save_req, 1);
            chk("R6 no early mask", mask_wr, 0);
        end
        save_done = 1'b1;
        step();
        save_done = 1'b0;
        chk("R6 mask_wr", mask_wr, 1);
        chk(n ? "R7 nmi mask all ones" : "R6 mask value", mask_new, em);
        chk("R5 save dropped", save_req, 0);
        step();
        chk("R8 jump", jump_req, 1);
        chk("R6 mask one cycle", mask_wr, 0);
        chk("R9 vector held", acc_vector, ev);
        chk("R9 mask held", mask_new, em);
        noise(0);
        step();
        chk("R8 jump one cycle", jump_req, 0);
        chk("R9 no accept after busy", accept, 0);
        chk("R8 idle no fetch", vec_fetch_req, 0);
    endtask

    // Watchdog: counts cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357));
        @(negedge clk);
        nmi_req = 1'b1;
        step();
        chk("R10 reset accept", accept, 0);
        chk("R10 reset fetch", vec_fetch_req, 0);
        chk("R10 reset mask_wr", mask_wr, 0);
        chk("R10 reset jump", jump_req, 0);
        nmi_req = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R10 after reset accept", accept, 0);
        chk("R10 after reset save", save_req, 0);

        run(1, 0, 4'h0, 8'h20, 4'hF, 0, 0, 0); // R1 nmi at top mask
        run(0, 1, 4'hF, 8'h44, 4'hE, 2, 1, 1); // R2 just above mask
        run(0, 1, 4'h5, 8'h45, 4'h5, 0, 0, 0); // R2 equal refused
        run(0, 1, 4'h0, 8'h46, 4'h0, 0, 0, 0); // R2 level 0 refused
        run(0, 0, 4'hF, 8'h47, 4'h0, 0, 0, 0); // R2 no request
        run(1, 1, 4'hF, 8'h48, 4'h0, 1, 2, 1); // R3 tie, R7
        run(0, 1, 4'h1, 8'h49, 4'h0, 3, 3, 1); // R6 low level

        for (int r = 0; r < 300; r++) begin
            run(1'($urandom_range(0, 7) == 0), 1'($urandom), 4'($urandom),
                8'($urandom), 4'($urandom), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 3)), 1'($urandom));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule